// File: doc/BRIEF.md
# Shortened Cyclic FEC Block Encoder

This block turns a stream of 66-bit line words into (2112,2080) forward-error-correction codewords. The words arrive already 64B/66B encoded and scrambled. Each word gives up one of its two sync-header bits, so 32 words carry 2080 payload bits. The encoder runs a 32-bit cyclic parity over those payload bits and appends it after them. The output is again 66 bits per accepted input word, so the serial line rate does not change. The code lets a far-end decoder repair error bursts of up to 11 bits.

Four negotiation qualifier inputs decide whether coding is active. Coding runs only when both ends advertise the ability and at least one end asks for it. When coding is off, words pass through one register unchanged. When coding is on, the first word of a fresh stream produces no output. Each later accepted word releases 66 coded bits. The leftover payload and the parity of a finished codeword leave on the first word of the next codeword. A strobe marks the output word that opens each codeword.

Top module: `fec74_block_encoder`

## Requirements
- R1: Coding is active exactly when loc_able and rem_able are both 1 and at least one of loc_req, rem_req is 1. With both able bits set and neither request bit set, coding stays off.
- R2: While coding is off, each cycle with in_valid=1 produces, on the next clock, out_valid=1, out_word equal to that in_word and out_sof=0.
- R3: While coding is on, in_word[65:64] is the sync header (01 marks data, 10 marks control) and in_word[63:0] is the payload. The 65-bit group for a word is in_word[64:0]: the kept header bit first, then the 64 payload bits in their original order.
- R4: The parity is the remainder of the 2080 payload bits, times x^32, divided by g(x) = x^32 + x^23 + x^21 + x^11 + x^2 + 1. Payload bits are taken first bit first, the register starts at zero for every codeword, and the remainder is sent most significant bit first.
- R5: A codeword is the 2080 payload bits, the groups of its 32 words in arrival order, followed by the 32 parity bits: 2112 bits in total. It leaves as 32 output words, and out_word[65] is the earliest bit of each output word.
- R6: While coding is on, the first accepted word after coding turns on produces no output. Every later accepted word produces exactly one output word on the next clock.
- R7: out_sof is 1 only together with out_valid, and only on the output word that carries the first 66 bits of a codeword.
- R8: A cycle with in_valid=0 produces out_valid=0 on the next clock and leaves the codeword in progress intact.
- R9: While reset is held, out_valid and out_sof are 0.
- R10: Turning coding off discards any partial codeword and any pending parity. After coding turns back on, the next accepted word starts a fresh codeword and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| loc_able | input | 1 | Local end advertises FEC ability |
| rem_able | input | 1 | Remote end advertises FEC ability |
| loc_req | input | 1 | Local end requests FEC |
| rem_req | input | 1 | Remote end requests FEC |
| in_valid | input | 1 | in_word holds a word this cycle |
| in_word | input | 66 | Line word: [65:64] sync header, [63:0] payload, bit 65 earliest |
| out_valid | output | 1 | out_word holds an output word |
| out_word | output | 66 | Output word, bit 65 earliest |
| out_sof | output | 1 | This output word opens a codeword |

## Verification
The assertions assume that the qualifier inputs change only between codewords or while coding is off. They also assume that in_word is meaningful only when in_valid is high and that the header bits of a coded word are 01 or 10. The stimulus changes qualifier levels only between separate sub-tests or deliberately mid-codeword to test the discard rule. It always builds headers as a complementary pair, and it inserts idle cycles only between accepted words, so the codeword model in the bench stays aligned with the design.

// File: rtl/fec74_pkg.sv
package fec74_pkg;
  localparam int WORD_W    = 66;
  localparam int BLK_WORDS = 32;
  localparam int PAR_W     = 32;
  localparam int GRP_W     = WORD_W - 1;
  localparam int PAY_W     = GRP_W * BLK_WORDS;
  localparam int CW_W      = PAY_W + PAR_W;
  localparam int TAIL_W    = WORD_W - PAR_W;
  localparam int IDX_W     = $clog2(BLK_WORDS);
  localparam logic [PAR_W-1:0] GEN_POLY = 32'h00A0_0805;
endpackage

// File: rtl/fec_ability_qual.sv
module fec_ability_qual (
  input  logic loc_able,
  input  logic rem_able,
  input  logic loc_req,
  input  logic rem_req,
  output logic coding_on
);
  always_comb begin
    coding_on = loc_able & rem_able & (loc_req | rem_req);
  end
endmodule

// File: rtl/fec_parity_lfsr.sv
module fec_parity_lfsr
  import fec74_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             restart,
  input  logic [GRP_W-1:0] grp,
  output logic [PAR_W-1:0] par_q
);
  logic [PAR_W-1:0] par_d;

  function automatic logic [PAR_W-1:0] absorb(input logic [PAR_W-1:0] seed,
                                              input logic [GRP_W-1:0] bits);
    logic [PAR_W-1:0] s;
    logic fb;
    s = seed;
    for (int i = GRP_W - 1; i >= 0; i--) begin
      fb = bits[i] ^ s[PAR_W-1];
      s  = {s[PAR_W-2:0], 1'b0} ^ (fb ? GEN_POLY : '0);
    end
    return s;
  endfunction

  always_comb begin
    par_d = par_q;
    if (clr) begin
      par_d = '0;
    end else if (step) begin
      par_d = absorb(restart ? '0 : par_q, grp);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= '0;
    end else begin
      par_q <= par_d;
    end
  end
endmodule

// File: rtl/fec_bit_packer.sv
module fec_bit_packer
  import fec74_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic              first,
  input  logic [IDX_W-1:0]  shamt,
  input  logic [GRP_W-1:0]  grp,
  output logic [WORD_W-1:0] emit,
  output logic [TAIL_W-1:0] tail
);
  localparam int MRG_W = 2 * GRP_W;
  localparam int LEFT  = MRG_W - WORD_W;

  logic [GRP_W-1:0] res_q, res_d;
  logic [MRG_W-1:0] merged;

  // residue is left aligned, unused low bits stay zero
  always_comb begin
    merged = {res_q, {GRP_W{1'b0}}} | ({{GRP_W{1'b0}}, grp} << shamt);
    emit   = merged[MRG_W-1 -: WORD_W];
    tail   = res_q[GRP_W-1 -: TAIL_W];
  end

  always_comb begin
    res_d = res_q;
    if (clr) begin
      res_d = '0;
    end else if (step) begin
      if (first) begin
        res_d = grp;
      end else begin
        res_d = {merged[LEFT-1:0], {(GRP_W-LEFT){1'b0}}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else begin
      res_q <= res_d;
    end
  end
endmodule

// File: rtl/fec74_block_encoder.sv
module fec74_block_encoder
  import fec74_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_able,
  input  logic              rem_able,
  input  logic              loc_req,
  input  logic              rem_req,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_sof
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_WORDS - 1);

  logic [1:0]        rs_q;
  logic              srst_n;
  logic              fec_on;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              pend_q, pend_d;
  logic              step, first;
  logic [PAR_W-1:0]  par_q;
  logic [WORD_W-1:0] emit;
  logic [TAIL_W-1:0] tail;
  logic              ov_d, sof_d;
  logic [WORD_W-1:0] ow_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign srst_n = rs_q[1];

  fec_ability_qual u_qual (
    .loc_able (loc_able),
    .rem_able (rem_able),
    .loc_req  (loc_req),
    .rem_req  (rem_req),
    .coding_on(fec_on)
  );

  assign step  = fec_on & in_valid;
  assign first = (idx_q == '0);

  fec_parity_lfsr u_lfsr (
    .clk    (clk),
    .rst_n  (srst_n),
    .clr    (!fec_on),
    .step   (step),
    .restart(first),
    .grp    (in_word[GRP_W-1:0]),
    .par_q  (par_q)
  );

  fec_bit_packer u_pack (
    .clk  (clk),
    .rst_n(srst_n),
    .clr  (!fec_on),
    .step (step),
    .first(first),
    .shamt(idx_q - 1'b1),
    .grp  (in_word[GRP_W-1:0]),
    .emit (emit),
    .tail (tail)
  );

  always_comb begin
    idx_d  = idx_q;
    pend_d = pend_q;
    if (!fec_on) begin
      idx_d  = '0;
      pend_d = 1'b0;
    end else if (in_valid) begin
      idx_d  = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      pend_d = (idx_q == LAST_IDX);
    end
  end

  always_comb begin
    ov_d  = 1'b0;
    sof_d = 1'b0;
    ow_d  = out_word;
    if (in_valid) begin
      if (!fec_on) begin
        ov_d = 1'b1;
        ow_d = in_word;
      end else if (first) begin
        ov_d = pend_q;
        ow_d = {tail, par_q};
      end else begin
        ov_d  = 1'b1;
        ow_d  = emit;
        sof_d = (idx_q == IDX_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      idx_q     <= '0;
      pend_q    <= 1'b0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_word  <= '0;
    end else begin
      idx_q     <= idx_d;
      pend_q    <= pend_d;
      out_valid <= ov_d;
      out_sof   <= sof_d;
      out_word  <= ow_d;
    end
  end

  // R2
  pass_thru_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!fec_on && in_valid) |=> (out_valid && !out_sof && out_word == $past(in_word)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> !out_valid);

  // R7
  sof_slot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fec_on && in_valid && idx_q == IDX_W'(1)) |=> out_sof);

  // R7
  sof_valid_chk: assert property (@(posedge clk) disable iff (!srst_n)
    out_sof |-> out_valid);

  // R10
  fresh_start_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ($rose(fec_on) && in_valid) |=> !out_valid);
endmodule

// File: tb/fec74_block_encoder_bench.sv
module fec74_block_encoder_bench;
  localparam logic [31:0] POLY = 32'h00A0_0805;
  localparam int NW = 65;

  // {loc_able, rem_able, loc_req, rem_req, expected coding_on}
  localparam logic [4:0] QTAB [16] = '{
    5'b0000_0, 5'b0001_0, 5'b0010_0, 5'b0011_0,
    5'b0100_0, 5'b0101_0, 5'b0110_0, 5'b0111_0,
    5'b1000_0, 5'b1001_0, 5'b1010_0, 5'b1011_0,
    5'b1100_0, 5'b1101_1, 5'b1110_1, 5'b1111_1
  };

  logic clk, rst_n, loc_able, rem_able, loc_req, rem_req, in_valid;
  logic [65:0] in_word, out_word;
  logic out_valid, out_sof;
  int checks, errors;
  bit done;
  logic [31:0] seed;
  logic [65:0] w [NW];
  logic [2111:0] cw0, cw1;

  fec74_block_encoder u_fec74_block_encoder (
    .clk(clk), .rst_n(rst_n), .loc_able(loc_able), .rem_able(rem_able),
    .loc_req(loc_req), .rem_req(rem_req), .in_valid(in_valid),
    .in_word(in_word), .out_valid(out_valid), .out_word(out_word),
    .out_sof(out_sof)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic [65:0] d);
    in_valid = v;
    in_word  = d;
    @(negedge clk);
  endtask

  task automatic set_q(input logic [3:0] q);
    {loc_able, rem_able, loc_req, rem_req} = q;
  endtask

  function automatic logic [65:0] rnd_word();
    logic [65:0] r;
    seed = seed * 32'd1664525 + 32'd1013904223;
    r[63:32] = seed;
    seed = seed * 32'd1664525 + 32'd1013904223;
    r[31:0] = seed;
    r[64] = seed[17];
    r[65] = ~seed[17];
    return r;
  endfunction

  function automatic logic [2111:0] make_cw(input int base);
    logic [2111:0] c;
    logic [31:0] p;
    logic fb;
    c = '0;
    for (int i = 0; i < 32; i++) c[2111-65*i -: 65] = w[base+i][64:0];
    p = '0;
    for (int b = 2111; b >= 32; b--) begin
      fb = c[b] ^ p[31];
      p = {p[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
    end
    c[31:0] = p;
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0; seed = 32'h1234_5678;
    rst_n = 1'b0; set_q(4'b0000); in_valid = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 out_valid", {65'b0, out_valid}, 66'b0);
    chk("R9 out_sof", {65'b0, out_sof}, 66'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 qualifier table, observed through first-word behaviour
    foreach (QTAB[i]) begin
      logic [65:0] t;
      t = rnd_word();
      set_q(4'b0000);
      send(1'b0, '0);
      set_q(QTAB[i][4:1]);
      send(1'b1, t);
      if (QTAB[i][0]) begin
        chk("R1 on: first word silent", {65'b0, out_valid}, 66'b0);
      end else begin
        chk("R1/R2 off: pass-through word", out_valid ? out_word : 66'bx, t);
      end
      send(1'b0, '0);
    end

    // R3 R4 R5 R6 R7 R8: two full codewords with idle gaps
    for (int i = 0; i < NW; i++) w[i] = rnd_word();
    cw0 = make_cw(0);
    cw1 = make_cw(32);
    set_q(4'b0000);
    send(1'b0, '0);
    set_q(4'b1110);
    for (int n = 0; n < NW; n++) begin
      if (n % 7 == 3) begin
        send(1'b0, '0);
        chk("R8 idle gives no output", {65'b0, out_valid}, 66'b0);
      end
      send(1'b1, w[n]);
      if (n == 0) begin
        chk("R6 first word silent", {65'b0, out_valid}, 66'b0);
      end else begin
        int k;
        logic [65:0] e;
        k = (n - 1) % 32;
        e = ((n - 1) < 32) ? cw0[2111-66*k -: 66] : cw1[2111-66*k -: 66];
        chk("R6 output present", {65'b0, out_valid}, 66'd1);
        chk("R3 R4 R5 codeword word", out_word, e);
        chk("R7 sof position", {65'b0, out_sof}, {65'b0, (k == 0)});
      end
    end

    // R10: partial codeword, turn off, pass-through, turn on
    for (int n = 0; n < 5; n++) send(1'b1, rnd_word());
    set_q(4'b1100);
    begin
      logic [65:0] t;
      t = rnd_word();
      send(1'b1, t);
      chk("R2 off mid-stream pass-through", out_word, t);
      chk("R2 no sof when off", {65'b0, out_sof}, 66'b0);
    end
    set_q(4'b1101);
    send(1'b1, rnd_word());
    chk("R10 fresh codeword silent", {65'b0, out_valid}, 66'b0);
    send(1'b1, rnd_word());
    chk("R10 next word opens codeword", {65'b0, out_sof}, 66'd1);

    // R9 reset during a codeword
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 valid cleared by reset", {65'b0, out_valid}, 66'b0);
    rst_n = 1'b1;
    send(1'b0, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule